// File: doc/BRIEF.md
# Cascadable 8/16-bit Match Timer

The block holds two 8-bit up-counters. Each counter runs from a count clock picked out of a free-running prescaler or from its own external counter pin. A counter counts up from zero to the value in its compare register. On the count-enable cycle where it equals that value, it returns to zero and sets its interrupt flag. Mode bits in the high timer's mode register chain the two counters into one 16-bit timer. In that mode the low timer's clock select, start bit and enable bit drive both bytes. The pair then matches against the 16-bit value formed from the two compare registers, and it reports only on the low interrupt line.

Software writes the mode and compare registers through a write-enable, address and data port. Writing a mode register with its start bit set clears that counter and starts it. Writing the start bit as zero freezes the count. The interrupt flags stay set until software clears them with a per-line clear strobe.

Top module: `casc_timer`

## Requirements
- R1: After reset all mode and compare registers are 0x00, both counts read 0, and both interrupt flags are 0.
- R2: The low mode register is at address 0 and holds clock select in bits [4:2]. The select codes are 000 = clock/2, 001 = /4, 010 = /8, 011 = /32, 100 = /128, 101 = /512, 110 = /2048 and 111 = external low pin. With an internal select, a running counter advances exactly once per division period.
- R3: Each external pin passes through a two-stage synchronizer. Only a rising edge counts. The count changes on the third rising clock edge after the pin rises, and a pin held high adds nothing more.
- R4: In either mode register, bit 0 is the start bit. Writing it as 1 clears that counter to 0 on the write edge and lets it run. Writing it as 0 stops the counter, which then holds its value.
- R5: In either mode register, bit 1 is the counter enable. While it is 0 the count holds and no match is taken, even when the count equals the compare value.
- R6: In 8-bit operation a counter counts 0 up to its compare value (compare low at address 2, compare high at address 3). On the next count-enable cycle it returns to 0 and sets its own flag (irq_o[0] for low, irq_o[1] for high). A compare value of 0 therefore gives a match on every count-enable cycle.
- R7: The high mode register is at address 1. Chained 16-bit operation is active only when its bits [3:2] are 11 and its bit 6 is 1. In chained operation the high byte advances only when the low byte rolls over from 0xFF to 0x00.
- R8: In chained operation the match is taken on the full 16-bit value against {compare high, compare low}. On the match both bytes return to 0 and irq_o[0] is set. irq_o[1] is never set.
- R9: A flag stays set until a 1 on its bit of irq_clr_i. A match and a clear in the same cycle leave the flag set.
- R10: In 8-bit operation the high timer's select in bits [3:2] is 00 = clock/2, 01 = /8, 10 = /32 or 11 = external high pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| irq_clr_i | input | 2 | Write-1-to-clear strobes for the flags |
| ext_lo_i | input | 1 | External count pin, low timer |
| ext_hi_i | input | 1 | External count pin, high timer |
| cnt_lo_o | output | 8 | Low counter value |
| cnt_hi_o | output | 8 | High counter value |
| irq_o | output | 2 | Interrupt flags: [0] low/chained, [1] high |

## Verification
A register write takes effect on the clock edge that captures it. A start-bit clear therefore shows at the sampling point one clock edge after the write. An external pin rise shows in the count on the third clock edge after the rise. The bench confirms this by sampling once after the second edge and once after the third. Match and flag updates land on that same third edge. Prescaler rates are not tied to the prescaler phase: the bench reads the count at two falling edges set a whole number of division periods apart and expects the exact difference. All sampling happens on falling edges, and inputs change only there.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam int unsigned NUM_TAPS = 7;
  localparam logic [2:0] ADDR_MODE_LO = 3'd0;
  localparam logic [2:0] ADDR_MODE_HI = 3'd1;
  localparam logic [2:0] ADDR_CMP_LO  = 3'd2;
  localparam logic [2:0] ADDR_CMP_HI  = 3'd3;
  localparam logic [1:0] SEL_HI_EXT   = 2'b11;

  // log2 of division ratio per prescaler tap
  function automatic int unsigned tap_log2(input int unsigned idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 5;
      4: return 7;
      5: return 9;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/cst_prescaler.sv
module cst_prescaler #(
  parameter int unsigned PRE_W    = 11,
  parameter int unsigned NUM_TAPS = cst_pkg::NUM_TAPS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_TAPS-1:0] tick_o
);
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam int unsigned LG = cst_pkg::tap_log2(k);
    assign tick_o[k] = &div_q[LG-1:0];
  end
endmodule

// File: rtl/cst_edge_det.sv
module cst_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/cst_counter_core.sv
module cst_counter_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chain_i,
  input  logic             tick_lo_i,
  input  logic             tick_hi_i,
  input  logic             run_lo_i,
  input  logic             run_hi_i,
  input  logic             clr_lo_i,
  input  logic             clr_hi_i,
  input  logic [CNT_W-1:0] cmp_lo_i,
  input  logic [CNT_W-1:0] cmp_hi_i,
  output logic [CNT_W-1:0] cnt_lo_o,
  output logic [CNT_W-1:0] cnt_hi_o,
  output logic             match_lo_o,
  output logic             match_hi_o
);
  localparam int unsigned WIDE_W = 2 * CNT_W;

  logic [CNT_W-1:0]  lo_q, hi_q, lo_d, hi_d;
  logic [WIDE_W-1:0] wide, wide_cmp, wide_nxt;

  assign wide     = {hi_q, lo_q};
  assign wide_cmp = {cmp_hi_i, cmp_lo_i};
  assign wide_nxt = wide + 1'b1;  // carry into high byte only on low rollover

  always_comb begin
    lo_d       = lo_q;
    hi_d       = hi_q;
    match_lo_o = 1'b0;
    match_hi_o = 1'b0;
    if (chain_i) begin
      if (clr_lo_i) begin
        lo_d = '0;
        hi_d = '0;
      end else if (run_lo_i && tick_lo_i) begin
        if (wide == wide_cmp) begin
          lo_d       = '0;
          hi_d       = '0;
          match_lo_o = 1'b1;
        end else begin
          {hi_d, lo_d} = wide_nxt;
        end
      end
    end else begin
      if (clr_lo_i) lo_d = '0;
      else if (run_lo_i && tick_lo_i) begin
        if (lo_q == cmp_lo_i) begin
          lo_d       = '0;
          match_lo_o = 1'b1;
        end else lo_d = lo_q + 1'b1;
      end
      if (clr_hi_i) hi_d = '0;
      else if (run_hi_i && tick_hi_i) begin
        if (hi_q == cmp_hi_i) begin
          hi_d       = '0;
          match_hi_o = 1'b1;
        end else hi_d = hi_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_lo_o = lo_q;
  assign cnt_hi_o = hi_q;
endmodule

// File: rtl/casc_timer.sv
module casc_timer #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PRE_W       = 11,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       irq_clr_i,
  input  logic             ext_lo_i,
  input  logic             ext_hi_i,
  output logic [CNT_W-1:0] cnt_lo_o,
  output logic [CNT_W-1:0] cnt_hi_o,
  output logic [1:0]       irq_o
);
  import cst_pkg::*;

  // mode fields
  logic [2:0]       sel_lo_q;
  logic             en_lo_q, st_lo_q;
  logic [1:0]       sel_hi_q;
  logic             wide_bit_q, en_hi_q, st_hi_q;
  logic [CNT_W-1:0] cmp_lo_q, cmp_hi_q;
  logic [1:0]       irq_q;

  logic wr_mode_lo, wr_mode_hi, wr_cmp_lo, wr_cmp_hi;
  logic clr_lo, clr_hi, run_lo, run_hi, chain;
  logic tick_lo, tick_hi, rise_lo, rise_hi;
  logic match_lo, match_hi;
  logic [NUM_TAPS-1:0] pre_tick;
  logic [7:0]          lo_src;
  logic [1:0]          unused_data;

  assign unused_data = {wr_data_i[7], wr_data_i[5]};

  assign wr_mode_lo = wr_en_i && (wr_addr_i == ADDR_MODE_LO);
  assign wr_mode_hi = wr_en_i && (wr_addr_i == ADDR_MODE_HI);
  assign wr_cmp_lo  = wr_en_i && (wr_addr_i == ADDR_CMP_LO);
  assign wr_cmp_hi  = wr_en_i && (wr_addr_i == ADDR_CMP_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_lo_q   <= '0;
      en_lo_q    <= 1'b0;
      st_lo_q    <= 1'b0;
      sel_hi_q   <= '0;
      wide_bit_q <= 1'b0;
      en_hi_q    <= 1'b0;
      st_hi_q    <= 1'b0;
      cmp_lo_q   <= '0;
      cmp_hi_q   <= '0;
    end else begin
      if (wr_mode_lo) begin
        sel_lo_q <= wr_data_i[4:2];
        en_lo_q  <= wr_data_i[1];
        st_lo_q  <= wr_data_i[0];
      end
      if (wr_mode_hi) begin
        wide_bit_q <= wr_data_i[6];
        sel_hi_q   <= wr_data_i[3:2];
        en_hi_q    <= wr_data_i[1];
        st_hi_q    <= wr_data_i[0];
      end
      if (wr_cmp_lo) cmp_lo_q <= wr_data_i;
      if (wr_cmp_hi) cmp_hi_q <= wr_data_i;
    end
  end

  assign clr_lo = wr_mode_lo && wr_data_i[0];
  assign clr_hi = wr_mode_hi && wr_data_i[0];
  assign run_lo = en_lo_q && st_lo_q;
  assign run_hi = en_hi_q && st_hi_q;
  assign chain  = wide_bit_q && (sel_hi_q == SEL_HI_EXT);

  cst_prescaler #(.PRE_W(PRE_W), .NUM_TAPS(NUM_TAPS)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (pre_tick)
  );

  cst_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_edge_lo (
    .clk_i (clk_i), .rst_ni (rst_ni), .pin_i (ext_lo_i), .rise_o (rise_lo)
  );

  cst_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_edge_hi (
    .clk_i (clk_i), .rst_ni (rst_ni), .pin_i (ext_hi_i), .rise_o (rise_hi)
  );

  assign lo_src  = {rise_lo, pre_tick};
  assign tick_lo = lo_src[sel_lo_q];

  always_comb begin
    case (sel_hi_q)
      2'b00:   tick_hi = pre_tick[0];
      2'b01:   tick_hi = pre_tick[2];
      2'b10:   tick_hi = pre_tick[3];
      default: tick_hi = rise_hi;
    endcase
  end

  cst_counter_core #(.CNT_W(CNT_W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chain_i    (chain),
    .tick_lo_i  (tick_lo),
    .tick_hi_i  (tick_hi),
    .run_lo_i   (run_lo),
    .run_hi_i   (run_hi),
    .clr_lo_i   (clr_lo),
    .clr_hi_i   (clr_hi),
    .cmp_lo_i   (cmp_lo_q),
    .cmp_hi_i   (cmp_hi_q),
    .cnt_lo_o   (cnt_lo_o),
    .cnt_hi_o   (cnt_hi_o),
    .match_lo_o (match_lo),
    .match_hi_o (match_hi)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= (irq_q & ~irq_clr_i) | {match_hi, match_lo};
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/cst_checker.sv
module cst_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       irq_o,
  input logic [1:0]       irq_clr_i,
  input logic [CNT_W-1:0] cnt_lo_o,
  input logic [CNT_W-1:0] cnt_hi_o,
  input logic             chain,
  input logic             run_lo,
  input logic             tick_lo,
  input logic             clr_lo,
  input logic             match_lo
);
  p_irq_on_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_lo |=> irq_o[0]);

  p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[0] && !irq_clr_i[0]) |=> irq_o[0]);

  p_irq_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[0] && irq_clr_i[0] && !match_lo) |=> !irq_o[0]);

  p_start_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_lo |=> (cnt_lo_o == '0));

  p_hold_stopped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_lo && !clr_lo) |=> $stable(cnt_lo_o));

  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_lo && !clr_lo) |=> $stable(cnt_lo_o));

  p_hi_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain && !irq_o[1]) |=> !irq_o[1]);

  p_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain && run_lo && tick_lo && !clr_lo && !match_lo && (cnt_lo_o == '1))
    |=> (cnt_hi_o == CNT_W'($past(cnt_hi_o) + 1'b1)));
endmodule

bind casc_timer cst_checker #(.CNT_W(CNT_W)) i_cst_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_o     (irq_o),
  .irq_clr_i (irq_clr_i),
  .cnt_lo_o  (cnt_lo_o),
  .cnt_hi_o  (cnt_hi_o),
  .chain     (chain),
  .run_lo    (run_lo),
  .tick_lo   (tick_lo),
  .clr_lo    (clr_lo),
  .match_lo  (match_lo)
);

// File: tb/test_casc_timer.sv
module test_casc_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] irq_clr_i = '0;
  logic       ext_lo_i = 1'b0;
  logic       ext_hi_i = 1'b0;
  logic [7:0] cnt_lo_o, cnt_hi_o;
  logic [1:0] irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  casc_timer i_casc_timer (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .irq_clr_i,
    .ext_lo_i, .ext_hi_i, .cnt_lo_o, .cnt_hi_o, .irq_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic clr_irq(input logic [1:0] m);
    @(negedge clk_i);
    irq_clr_i = m;
    @(negedge clk_i);
    irq_clr_i = '0;
  endtask

  task automatic pulse(input bit hi, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (hi) ext_hi_i = 1'b1; else ext_lo_i = 1'b1;
      repeat (4) @(negedge clk_i);
      ext_hi_i = 1'b0; ext_lo_i = 1'b0;
      repeat (3) @(negedge clk_i);
    end
  endtask

  task automatic t_reset;
    chk("R1 cnt_lo", cnt_lo_o, 0);
    chk("R1 cnt_hi", cnt_hi_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_ext_latency;
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h1F);  // ext, en, start
    @(negedge clk_i); ext_lo_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R3 before third edge", cnt_lo_o, 0);
    @(negedge clk_i);
    chk("R3 at third edge", cnt_lo_o, 1);
    repeat (5) @(negedge clk_i);
    chk("R3 held high", cnt_lo_o, 1);
    ext_lo_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_match8;
    wr(3'd2, 8'd3);
    wr(3'd0, 8'h1F);
    pulse(0, 3);
    chk("R6 at compare", cnt_lo_o, 3);
    chk("R6 no irq yet", irq_o[0], 0);
    pulse(0, 1);
    chk("R6 wrap", cnt_lo_o, 0);
    chk("R6 irq set", irq_o[0], 1);
    pulse(0, 3);
    // clear strobe coincides with match edge
    @(negedge clk_i); ext_lo_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); irq_clr_i = 2'b01;
    @(negedge clk_i); irq_clr_i = 2'b00;
    chk("R9 set wins wrap", cnt_lo_o, 0);
    chk("R9 set wins", irq_o[0], 1);
    ext_lo_i = 1'b0;
    repeat (3) @(negedge clk_i);
    clr_irq(2'b01);
    chk("R9 cleared", irq_o[0], 0);
  endtask

  task automatic t_start_stop;
    pulse(0, 2);
    wr(3'd0, 8'h1E);  // start=0
    pulse(0, 2);
    chk("R4 stopped holds", cnt_lo_o, 2);
    wr(3'd0, 8'h1F);
    chk("R4 start clears", cnt_lo_o, 0);
    pulse(0, 1);
    chk("R4 runs again", cnt_lo_o, 1);
  endtask

  task automatic t_enable;
    wr(3'd2, 8'd0);
    wr(3'd0, 8'h1D);  // en=0, start=1
    clr_irq(2'b11);
    pulse(0, 2);
    chk("R5 hold count", cnt_lo_o, 0);
    chk("R5 no match", irq_o[0], 0);
    wr(3'd0, 8'h1F);
    pulse(0, 1);
    chk("R6 cmp zero count", cnt_lo_o, 0);
    chk("R6 cmp zero irq", irq_o[0], 1);
  endtask

  task automatic t_prescale(input logic [2:0] sel, input int per, input int n);
    int a;
    wr(3'd2, 8'hFF);
    wr(3'd0, {3'b000, sel, 2'b11});
    @(negedge clk_i);
    a = cnt_lo_o;
    repeat (per * n) @(negedge clk_i);
    chk($sformatf("R2 rate sel %0d", sel), int'(cnt_lo_o) - a, n);
  endtask

  task automatic t_hi8;
    int a;
    wr(3'd0, 8'h1E);
    wr(3'd3, 8'd1);
    wr(3'd1, 8'h0F);  // ext high, en, start
    clr_irq(2'b11);
    a = cnt_lo_o;
    pulse(1, 1);
    chk("R10 ext hi count", cnt_hi_o, 1);
    chk("R10 no irq yet", irq_o[1], 0);
    pulse(1, 1);
    chk("R6 hi wrap", cnt_hi_o, 0);
    chk("R6 hi irq", irq_o[1], 1);
    chk("R6 lo untouched", cnt_lo_o, a);
    wr(3'd3, 8'hFF);
    wr(3'd1, 8'h07);  // /8
    @(negedge clk_i);
    a = cnt_hi_o;
    repeat (64) @(negedge clk_i);
    chk("R10 hi rate /8", int'(cnt_hi_o) - a, 8);
  endtask

  task automatic t_chain;
    wr(3'd2, 8'd1);
    wr(3'd3, 8'd1);
    wr(3'd1, 8'h4F);
    wr(3'd0, 8'h1F);
    clr_irq(2'b11);
    pulse(0, 2);
    chk("R8 full-width compare", cnt_lo_o, 2);
    chk("R8 no early irq", irq_o[0], 0);
    pulse(0, 254);
    chk("R7 carry lo", cnt_lo_o, 0);
    chk("R7 carry hi", cnt_hi_o, 1);
    pulse(0, 1);
    chk("R8 at 0x0101", {cnt_hi_o, cnt_lo_o}, 16'h0101);
    chk("R8 no irq at compare", irq_o[0], 0);
    pulse(0, 1);
    chk("R8 wrap", {cnt_hi_o, cnt_lo_o}, 0);
    chk("R8 irq lo", irq_o[0], 1);
    chk("R8 irq hi quiet", irq_o[1], 0);
    wr(3'd1, 8'h4B);  // 16-bit bit, but select 10
    clr_irq(2'b01);
    pulse(0, 2);
    chk("R7 gated to 8-bit", cnt_lo_o, 0);
    chk("R7 gated irq", irq_o[0], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ext_latency();
    t_match8();
    t_start_stop();
    t_enable();
    t_prescale(3'd0, 2, 20);
    t_prescale(3'd2, 8, 10);
    t_prescale(3'd3, 32, 6);
    t_prescale(3'd6, 2048, 2);
    t_hi8();
    t_chain();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule